// File: doc/BRIEF.md
# Phase-Continuous Two-Tone FSK Transmit Modulator

This block produces the transmit waveform of a half-duplex 1200 bit/s frequency-shift-keyed link. A 460.8 kHz system clock drives a 16-bit phase accumulator. On every clock that accumulator advances by one of two constants, chosen by the serial NRZ data bit: the lower tone (near 1200 Hz) carries a 1 and the higher tone (near 2200 Hz) carries a 0. Because the data bit only selects the step size and never touches the stored phase, a change of bit bends the waveform without tearing it.

The phase is mapped to a trapezoid. It has a linear rise, a flat top, a linear fall and a flat bottom. The two ramps span half of the code range, centred on mid-scale, so each edge's slope grows in step with the tone frequency. The result leaves the block as an unsigned registered code for an external DAC. An active-low request-to-send input gates the modulator. While it is high, the output rests at mid-scale and the phase is cleared, so that every burst begins at the same point of the wave.

Top module: `fsk_tone_mod`

## Requirements
- R1: While `rst` is high, `dac_code` is 128 and the phase is zero. After reset is released, the first active sample is therefore 128.
- R2: On each clock edge where `req_send_n` is 1, the phase is cleared to 0 and `dac_code` becomes 128 on that edge.
- R3: On each edge where `req_send_n` is 0 and `tx_bit` is 1, the phase advances by 170, which is floor(1200*65536/460800). With the bit held at 1, rising crossings of 128 are spaced 385 or 386 clocks apart.
- R4: On each edge where `req_send_n` is 0 and `tx_bit` is 0, the phase advances by 312, which is floor(2200*65536/460800). With the bit held at 0, rising crossings of 128 are spaced 210 or 211 clocks apart.
- R5: A change of `tx_bit` while the modulator is active changes only the step size. The stored phase carries over unchanged.
- R6: On an active edge, `dac_code` takes the shape value of the phase held before that edge's increment. Let w = phase + 0x2000 (mod 65536) and k = w[13:7]. The shape value is then selected by w[15:14]: 0 gives 64+k (rising), 1 gives 192 (top), 2 gives 192-k (falling), 3 gives 64 (bottom).
- R7: Between two consecutive active samples, `dac_code` changes by no more than 3 codes. This holds across a change of `tx_bit`.
- R8: `dac_code` always stays within 64..192.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 460.8 kHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| req_send_n | input | 1 | Active-low transmit enable; high forces rest level and clears phase |
| tx_bit | input | 1 | NRZ data bit: 1 selects the low tone, 0 the high tone |
| dac_code | output | 8 | Registered unsigned sample code, 128 = mid-scale |

## Verification
The hardest case to provoke is a bit change that lands in the middle of a ramp or right at a segment boundary. That is where a phase reset or a wrong slope would show up as a jump. The stimulus therefore mixes random bit-time runs with a stretch of per-clock random toggling, so that changes fall in every segment. Each sample is compared against a bench model of the shape, and every step between active samples is bounded. Crossing intervals are measured only once a bit has been held for a full period, which separates a frequency error from a transition effect.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

  typedef enum logic [1:0] {
    SEG_RISE = 2'd0,
    SEG_TOP  = 2'd1,
    SEG_FALL = 2'd2,
    SEG_BOT  = 2'd3
  } seg_t;

  // Phase step per clock for a tone of hz at clock clk_hz with a w-bit accumulator.
  function automatic int unsigned calc_inc(input int unsigned hz,
                                           input int unsigned clk_hz,
                                           input int unsigned w);
    longint unsigned num;
    num = 64'(hz) << w;
    return 32'(num / 64'(clk_hz));
  endfunction

endpackage

// File: rtl/fsk_phase_nco.sv
module fsk_phase_nco #(
  parameter int unsigned CLK_HZ   = 460800,
  parameter int unsigned MARK_HZ  = 1200,
  parameter int unsigned SPACE_HZ = 2200,
  parameter int unsigned PHASE_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_send_n,
  input  logic               tx_bit,
  output logic [PHASE_W-1:0] phase
);

  localparam logic [PHASE_W-1:0] MARK_INC  =
    PHASE_W'(fsk_pkg::calc_inc(MARK_HZ, CLK_HZ, PHASE_W));
  localparam logic [PHASE_W-1:0] SPACE_INC =
    PHASE_W'(fsk_pkg::calc_inc(SPACE_HZ, CLK_HZ, PHASE_W));

  logic [PHASE_W-1:0] step;

  always_comb begin
    step = tx_bit ? MARK_INC : SPACE_INC;
  end

  always_ff @(posedge clk) begin
    if (rst || req_send_n) begin
      phase <= '0;
    end else begin
      phase <= phase + step;
    end
  end

  AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    req_send_n |=> (phase == '0)); // R2

  AST_MARK_STEP: assert property (@(posedge clk) disable iff (rst)
    (!req_send_n && tx_bit) |=> (phase == $past(phase) + MARK_INC)); // R3

  AST_SPACE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!req_send_n && !tx_bit) |=> (phase == $past(phase) + SPACE_INC)); // R4

endmodule

// File: rtl/fsk_trap_shaper.sv
module fsk_trap_shaper #(
  parameter int unsigned PHASE_W = 16,
  parameter int unsigned CODE_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_send_n,
  input  logic [PHASE_W-1:0] phase,
  output logic [CODE_W-1:0]  code
);

  localparam int unsigned RAMP_W  = CODE_W - 1;
  localparam int unsigned FRAC_W  = PHASE_W - 2;
  localparam logic [PHASE_W-1:0] OFFSET = PHASE_W'(1) << (PHASE_W - 3);
  localparam logic [CODE_W-1:0]  LOW  = CODE_W'(1) << (CODE_W - 2);
  localparam logic [CODE_W-1:0]  MID  = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0]  HIGH = LOW + MID;

  logic [PHASE_W-1:0] wp;
  logic [FRAC_W-1:0]  frac;
  logic [RAMP_W-1:0]  idx;
  fsk_pkg::seg_t      seg;
  logic [CODE_W-1:0]  shape;

  always_comb begin
    wp   = phase + OFFSET;
    frac = wp[FRAC_W-1:0];
    seg  = fsk_pkg::seg_t'(wp[PHASE_W-1 -: 2]);
  end

  generate
    if (FRAC_W >= RAMP_W) begin : g_ramp_shr
      assign idx = RAMP_W'(frac >> (FRAC_W - RAMP_W));
    end else begin : g_ramp_shl
      assign idx = RAMP_W'({frac, {(RAMP_W - FRAC_W){1'b0}}});
    end
  endgenerate

  always_comb begin
    unique case (seg)
      fsk_pkg::SEG_RISE: shape = LOW + CODE_W'(idx);
      fsk_pkg::SEG_TOP:  shape = HIGH;
      fsk_pkg::SEG_FALL: shape = HIGH - CODE_W'(idx);
      default:           shape = LOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || req_send_n) begin
      code <= MID;
    end else begin
      code <= shape;
    end
  end

  AST_IDLE_MID: assert property (@(posedge clk) disable iff (rst)
    req_send_n |=> (code == MID)); // R2

  AST_TOP_FLAT: assert property (@(posedge clk) disable iff (rst)
    (!req_send_n && seg == fsk_pkg::SEG_TOP) |=> (code == HIGH)); // R6

endmodule

// File: rtl/fsk_tone_mod.sv
module fsk_tone_mod #(
  parameter int unsigned CLK_HZ   = 460800,
  parameter int unsigned MARK_HZ  = 1200,
  parameter int unsigned SPACE_HZ = 2200,
  parameter int unsigned PHASE_W  = 16,
  parameter int unsigned CODE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_send_n,
  input  logic              tx_bit,
  output logic [CODE_W-1:0] dac_code
);

  localparam int unsigned MAX_INC  = fsk_pkg::calc_inc(
    (MARK_HZ > SPACE_HZ) ? MARK_HZ : SPACE_HZ, CLK_HZ, PHASE_W);
  localparam int unsigned SHIFT    = PHASE_W - 2 - (CODE_W - 1);
  localparam int unsigned MAX_STEP = (MAX_INC >> SHIFT) + 1;
  localparam logic [CODE_W-1:0] LOW  = CODE_W'(1) << (CODE_W - 2);
  localparam logic [CODE_W-1:0] HIGH = LOW + (CODE_W'(1) << (CODE_W - 1));
  localparam logic [CODE_W-1:0] MID  = CODE_W'(1) << (CODE_W - 1);

  logic [PHASE_W-1:0] phase;

  fsk_phase_nco #(
    .CLK_HZ(CLK_HZ), .MARK_HZ(MARK_HZ), .SPACE_HZ(SPACE_HZ), .PHASE_W(PHASE_W)
  ) u_nco (
    .clk(clk), .rst(rst), .req_send_n(req_send_n), .tx_bit(tx_bit), .phase(phase)
  );

  fsk_trap_shaper #(
    .PHASE_W(PHASE_W), .CODE_W(CODE_W)
  ) u_shaper (
    .clk(clk), .rst(rst), .req_send_n(req_send_n), .phase(phase), .code(dac_code)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (dac_code == MID && phase == '0)); // R1

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (dac_code >= LOW && dac_code <= HIGH)); // R8

  AST_SLEW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (!$past(req_send_n) && !$past(req_send_n, 2)) |->
      (((dac_code >= $past(dac_code)) ? (dac_code - $past(dac_code))
                                      : ($past(dac_code) - dac_code))
        <= CODE_W'(MAX_STEP))); // R7

  AST_BIT_KEEPS_PHASE: assert property (@(posedge clk) disable iff (rst)
    (!req_send_n && !$past(req_send_n) && tx_bit != $past(tx_bit))
      |=> (phase != '0 || $past(phase) != '0 || dac_code != MID)); // R5

endmodule

// File: tb/test_fsk_tone_mod.sv
`timescale 1ns/1ps
module test_fsk_tone_mod;

  localparam int CLK_PERIOD = 2170;
  localparam int MARK_STEP  = (1200 * 65536) / 460800;
  localparam int SPACE_STEP = (2200 * 65536) / 460800;
  localparam int SLEW_MAX   = 3;
  localparam int BIT_CLKS   = 384;

  logic       clk = 1'b0;
  logic       rst;
  logic       req_send_n;
  logic       tx_bit;
  logic [7:0] dac_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [15:0] m_phase;
  logic [7:0]  m_code;
  logic [7:0]  prev_code;
  bit          prev_active;
  logic        prev_tx;
  int          cyc;
  int          last_cross;
  bit          cross_valid;
  int          since_change;

  fsk_tone_mod i_fsk_tone_mod (
    .clk(clk), .rst(rst), .req_send_n(req_send_n), .tx_bit(tx_bit), .dac_code(dac_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int step_of(input logic b);
    return b ? MARK_STEP : SPACE_STEP;
  endfunction

  function automatic logic [7:0] ref_shape(input logic [15:0] ph);
    logic [15:0] w;
    int k;
    w = ph + 16'h2000;
    k = int'(w[13:7]);
    case (w[15:14])
      2'd0:    return 8'(64 + k);
      2'd1:    return 8'd192;
      2'd2:    return 8'(192 - k);
      default: return 8'd64;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  // Drive one clock of stimulus at a falling edge, predict, then sample at the next falling edge.
  task automatic step(input logic rs_n, input logic b);
    bit act;
    int lo;
    int gap;
    req_send_n = rs_n;
    tx_bit     = b;
    act        = !rs_n;
    if (rs_n) begin
      m_code  = 8'd128;
      m_phase = '0;
    end else begin
      m_code  = ref_shape(m_phase);
      m_phase = m_phase + 16'(step_of(b));
    end
    @(negedge clk);
    cyc++;
    if (rs_n)
      chk(dac_code == m_code, "R2 idle level", dac_code, m_code);
    else if (prev_active && b != prev_tx)
      chk(dac_code == m_code, "R5 phase kept over bit change", dac_code, m_code);
    else
      chk(dac_code == m_code, "R6 trapezoid sample", dac_code, m_code);
    if (act) begin
      chk(dac_code >= 8'd64 && dac_code <= 8'd192, "R8 code range", dac_code, 128);
    end
    if (act && prev_active) begin
      chk(((dac_code >= prev_code) ? int'(dac_code - prev_code) : int'(prev_code - dac_code))
          <= SLEW_MAX, "R7 slew step", int'(dac_code) - int'(prev_code), SLEW_MAX);
    end
    if (!act || b != prev_tx) begin
      since_change = 0;
      cross_valid  = 0;
    end else begin
      since_change++;
    end
    if (act && prev_active && prev_code < 8'd128 && dac_code >= 8'd128) begin
      if (cross_valid) begin
        gap = cyc - last_cross;
        lo  = 65536 / step_of(b);
        if (b) chk(gap == lo || gap == lo + 1, "R3 mark crossing period", gap, lo);
        else   chk(gap == lo || gap == lo + 1, "R4 space crossing period", gap, lo);
      end
      cross_valid = (since_change >= 1);
      last_cross  = cyc;
    end
    prev_code   = dac_code;
    prev_active = act;
    prev_tx     = b;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; req_send_n = 1'b0; tx_bit = 1'b1;
    m_phase = '0; prev_code = 8'd128; prev_active = 0; prev_tx = 1'b1;
    cyc = 0; last_cross = 0; cross_valid = 0; since_change = 0;
    repeat (3) @(negedge clk);
    chk(dac_code == 8'd128, "R1 reset level", dac_code, 128);
    rst = 1'b0;
    // R1: first active sample after reset comes from phase zero
    step(1'b0, 1'b1);
    chk(dac_code == 8'd128, "R1 first sample", dac_code, 128);
    repeat (5) step(1'b1, 1'b0);              // R2 idle
    repeat (1500) step(1'b0, 1'b1);           // R3 mark run
    repeat (1500) step(1'b0, 1'b0);           // R4 space run
    repeat (7) step(1'b1, 1'b1);              // R2 mid-burst stop clears phase
    step(1'b0, 1'b0);
    chk(dac_code == 8'd128, "R2 restart phase", dac_code, 128);
    for (int i = 0; i < 200; i++) step(1'b0, 1'($urandom % 2)); // R5 R7 per-clock toggling
    for (int nb = 0; nb < 40; nb++) begin
      logic idle;
      logic bv;
      idle = (($urandom % 8) == 0);
      bv   = 1'($urandom % 2);
      for (int j = 0; j < BIT_CLKS; j++) step(idle, bv);
    end
    for (int i = 0; i < 400; i++) step(1'b0, 1'(i % 3 == 0)); // R5 R7 patterned changes
    finish_run();
  end

endmodule